// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block models the command interface of a parallel NOR flash placed in front of a small on-chip byte array. Every bus write is treated as a command cycle. How a write is decoded depends on a write-cycle index and on the opcode latched in an earlier cycle. Through these cycles the block moves between array-read, status-read, identifier and query modes. It also carries out single-word program, whole-block erase and counted buffered program sequences.

An 8-bit status register collects the ready flag (bit 7), the erase-failure flag (bit 5) and the program-failure flag (bit 4). A read-only strap blocks every change to the array and raises the matching failure flag instead. Reads are registered. Depending on the current mode, a read returns little-endian array bytes, the status byte repeated on each device lane, identifier codes or query-table bytes.

A sequence the block does not recognise raises a one-cycle error pulse and drops the block back to array-read. The array can be loaded from a backdoor port for testing.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the block is in array-read mode at write-cycle 0, status reads 0x80, and rdata is 0.
- R2: An array-mode read returns the bytes at addr, addr+1 and so on, little-endian, with addresses wrapping modulo DEPTH. The access width is 1, 2 or 4 bytes (acc_bytes = 1, 2 or 4). Lanes beyond the width read as 0. The data appears on rdata one clock after the request.
- R3: In cycle 0, the opcodes 0xFF, 0xF0 and 0x00 (taken from wdata[7:0]) return the block to array-read mode.
- R4: Opcode 0x10 or 0x40 arms a program. The next write stores its acc_bytes bytes of data little-endian at its address and sets status bit 7. After that write the block stays in status-read mode.
- R5: With ro_strap high, a program leaves the array unchanged and sets status bit 4, and an erase leaves it unchanged and sets status bit 5.
- R6: Opcode 0x20 fills every byte of the BLOCK_BYTES-aligned block holding addr with 0xFF at once. In the following cycle, 0xD0 completes the erase, 0xFF returns to array-read, and any other value is a sequence error.
- R7: Opcode 0x50 clears status to 0x00 and returns to array-read. Opcode 0x70 enters status-read mode.
- R8: In every mode other than array, identifier and query, a read returns the status byte on the low byte of each DEV_BYTES-wide lane that lies within the access width. All other bits read as 0.
- R9: Opcode 0x90 enters identifier mode. Index 0 (addr shifted right by log2 DEV_BYTES) returns MFR_ID and index 1 returns DEV_ID, each repeated per lane. Any other index returns 0.
- R10: Opcode 0x98 enters query mode. Bytes 0x10 to 0x12 are 0x51, 0x52, 0x59. Byte 0x27 is log2 DEPTH, byte 0x2D is the block count minus 1, and index 0x40 reads 0. In query mode, 0xFF exits and any other write leaves the block in query mode.
- R11: Opcode 0x60 waits one cycle. There, 0xD0 or 0x01 completes with status bit 7 set and the block in status-read mode, and any other value returns to array-read without an error.
- R12: Opcode 0xE8 starts a buffered program. The next write loads a count N from the low DEV_BYTES*8 data bits, capped at BUF_WORDS-1. The following N+1 writes each store a word. The next write is then a confirm: 0xD0 completes with the block in status mode, and any other value aborts to array-read with the stored words kept.
- R13: An unrecognised opcode, or a bad erase confirm, pulses seq_err for one cycle (one clock after the write) and forces array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus request valid this cycle |
| we | input | 1 | 1 = write (command cycle), 0 = read |
| addr | input | AW | Byte address |
| acc_bytes | input | 3 | Access width in bytes: 1, 2 or 4 |
| wdata | input | 32 | Write data; opcode in bits 7:0 |
| ro_strap | input | 1 | Array is read-only when high |
| bd_we | input | 1 | Backdoor array byte write |
| bd_addr | input | AW | Backdoor byte address |
| bd_data | input | 8 | Backdoor byte data |
| rdata | output | 32 | Registered read data |
| seq_err | output | 1 | One-cycle pulse on an unrecognised sequence |

## Verification
Array reads at random addresses and widths, including wrap at the top of the array, separate correct byte ordering and lane masking from stale or misaligned data. Random program sequences with both program opcodes are followed by readback, which separates real stores from status-only responses. Directed sequences exercise erase at block boundaries, the read-only strap, each mode-entry opcode and each confirm and abort path, including a buffered program whose count exceeds the window. Together they tell apart the cycle-index decode, the capped counter and the error path.

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
  parameter int DEPTH       = 256,
  parameter int BLOCK_BYTES = 64,
  parameter int BUF_WORDS   = 16,
  parameter int DEV_BYTES   = 1,
  parameter logic [15:0] MFR_ID = 16'h0089,
  parameter logic [15:0] DEV_ID = 16'h0018,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    acc_bytes,
  input  logic [31:0]   wdata,
  input  logic          ro_strap,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [7:0]    bd_data,
  output logic [31:0]   rdata,
  output logic          seq_err
);
  localparam int BSH   = $clog2(BLOCK_BYTES);
  localparam int NBLK  = DEPTH / BLOCK_BYTES;
  localparam int LW    = DEV_BYTES * 8;
  localparam int CW    = DEV_BYTES * 8;
  localparam int IX_SH = $clog2(DEV_BYTES);

  localparam logic [7:0] C_ARR = 8'h00, C_PRG1 = 8'h10, C_PRG2 = 8'h40, C_ERA = 8'h20,
                         C_CLR = 8'h50, C_LCK = 8'h60, C_STS = 8'h70, C_ID = 8'h90,
                         C_QRY = 8'h98, C_BUF = 8'hE8, C_OK = 8'hD0, C_RA = 8'hFF,
                         C_RA2 = 8'hF0, C_UNL = 8'h01;

  logic [7:0]    mem [DEPTH];
  logic [7:0]    cmd, status;
  logic [1:0]    cyc;
  logic [CW-1:0] cnt;
  logic [2:0]    nb;
  logic [7:0]    op, qix;
  logic          wr_hit, do_store, do_erase;
  logic [31:0]   arr_word, rd_word;

  assign nb     = (acc_bytes == 3'd4) ? 3'd4 : (acc_bytes == 3'd2) ? 3'd2 : 3'd1;
  assign op     = wdata[7:0];
  assign wr_hit = req && we;
  assign qix    = 8'(addr >> IX_SH);
  assign do_erase = wr_hit && !ro_strap && cyc == 2'd0 && op == C_ERA;
  assign do_store = wr_hit && !ro_strap &&
                    ((cyc == 2'd1 && (cmd == C_PRG1 || cmd == C_PRG2)) ||
                     (cyc == 2'd2 && cmd == C_BUF));

  function automatic logic [31:0] lanes(input logic [15:0] v, input logic [2:0] n);
    lanes = '0;
    for (int l = 0; l < 4 / DEV_BYTES; l++)
      if (l * DEV_BYTES < int'(n)) lanes[l*LW +: LW] = v[LW-1:0];
  endfunction

  function automatic logic [7:0] qtab(input logic [7:0] ix);
    case (ix)
      8'h10: qtab = 8'h51;
      8'h11: qtab = 8'h52;
      8'h12: qtab = 8'h59;
      8'h13: qtab = 8'h01;
      8'h15: qtab = 8'h31;
      8'h27: qtab = 8'(AW);
      8'h2A: qtab = 8'($clog2(BUF_WORDS));
      8'h2C: qtab = 8'h01;
      8'h2D: qtab = 8'(NBLK - 1);
      8'h2E: qtab = 8'((NBLK - 1) >> 8);
      8'h2F: qtab = 8'(BLOCK_BYTES >> 8);
      8'h30: qtab = 8'(BLOCK_BYTES >> 16);
      default: qtab = 8'h00;
    endcase
  endfunction

  always_comb begin
    arr_word = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(nb)) arr_word[8*k +: 8] = mem[addr + AW'(k)];
  end

  always_comb begin
    case (cmd)
      C_ARR:   rd_word = arr_word;
      C_ID:    rd_word = lanes((qix == 8'd0) ? MFR_ID : (qix == 8'd1) ? DEV_ID : 16'h0, nb);
      C_QRY:   rd_word = lanes({8'h00, qtab(qix)}, nb);
      default: rd_word = lanes({8'h00, status}, nb);
    endcase
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_erase && (AW'(i) >> BSH) == (addr >> BSH)) mem[i] <= 8'hFF;
      for (int k = 0; k < 4; k++)
        if (do_store && k < int'(nb) && addr + AW'(k) == AW'(i)) mem[i] <= wdata[8*k +: 8];
      if (bd_we && bd_addr == AW'(i)) mem[i] <= bd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 2'd0; cmd <= C_ARR; status <= 8'h80; cnt <= '0;
      seq_err <= 1'b0; rdata <= '0;
    end else begin
      seq_err <= 1'b0;
      if (req && !we) rdata <= rd_word;
      if (wr_hit) begin
        case (cyc)
          2'd0: case (op)
            C_ARR, C_RA2, C_RA: cmd <= C_ARR;
            C_PRG1, C_PRG2, C_LCK, C_QRY: begin cyc <= 2'd1; cmd <= op; end
            C_ERA: begin
              status <= status | 8'h80 | (ro_strap ? 8'h20 : 8'h00);
              cyc <= 2'd1; cmd <= op;
            end
            C_CLR: begin status <= 8'h00; cmd <= C_ARR; end
            C_STS, C_ID: cmd <= op;
            C_BUF: begin status <= status | 8'h80; cyc <= 2'd1; cmd <= op; end
            default: begin seq_err <= 1'b1; cmd <= C_ARR; end
          endcase
          2'd1: case (cmd)
            C_PRG1, C_PRG2: begin
              status <= status | 8'h80 | (ro_strap ? 8'h10 : 8'h00);
              cyc <= 2'd0;
            end
            C_ERA: begin
              cyc <= 2'd0;
              if (op == C_OK) status <= status | 8'h80;
              else begin
                cmd <= C_ARR;
                if (op != C_RA) seq_err <= 1'b1;
              end
            end
            C_BUF: begin
              cnt <= (wdata[CW-1:0] > CW'(BUF_WORDS - 1)) ? CW'(BUF_WORDS - 1) : wdata[CW-1:0];
              cyc <= 2'd2;
            end
            C_LCK: begin
              cyc <= 2'd0;
              if (op == C_OK || op == C_UNL) status <= status | 8'h80;
              else cmd <= C_ARR;
            end
            C_QRY: if (op == C_RA) begin cyc <= 2'd0; cmd <= C_ARR; end
            default: begin seq_err <= 1'b1; cyc <= 2'd0; cmd <= C_ARR; end
          endcase
          2'd2: begin
            status <= status | 8'h80 | (ro_strap ? 8'h10 : 8'h00);
            if (cnt == '0) cyc <= 2'd3;
            else cnt <= cnt - 1'b1;
          end
          default: begin
            cyc <= 2'd0;
            if (op == C_OK) status <= status | 8'h80;
            else cmd <= C_ARR;
          end
        endcase
      end
    end
  end

  a_r13_err_to_array: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (cyc == 2'd0 && cmd == C_ARR));
  a_r12_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BUF_WORDS - 1));
  a_r12_confirm_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> cmd == C_BUF);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cyc == 2'd0 && op == C_CLR) |=> (status == 8'h00 && cmd == C_ARR));
  a_r5_ro_program: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ro_strap && cyc == 2'd1 && (cmd == C_PRG1 || cmd == C_PRG2)) |=> status[4]);
  a_r4_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cyc == 2'd1 && (cmd == C_PRG1 || cmd == C_PRG2)) |=> (status[7] && cyc == 2'd0));
  a_r6_erase_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (do_erase && !bd_we) |=> mem[$past(addr)] == 8'hFF);
endmodule

// File: tb/sim_nor_cmd_engine.sv
module sim_nor_cmd_engine;
  logic clk = 0, rst_n = 0, req = 0, we = 0, ro = 0, bd_we = 0;
  logic [7:0] addr = 0, bd_addr = 0, bd_data = 0;
  logic [2:0] acc = 1;
  logic [31:0] wdata = 0, rdata;
  logic seq_err, last_err;
  logic [7:0] sh [256];
  int n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  nor_cmd_engine u0 (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .acc_bytes(acc), .wdata(wdata), .ro_strap(ro), .bd_we(bd_we), .bd_addr(bd_addr),
    .bd_data(bd_data), .rdata(rdata), .seq_err(seq_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] w);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; acc = w;
    @(negedge clk); req = 0; we = 0; last_err = seq_err;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] w, output logic [31:0] r);
    @(negedge clk); req = 1; we = 0; addr = a; acc = w;
    @(negedge clk); req = 0; r = rdata;
  endtask

  function automatic logic [31:0] exp_arr(input logic [7:0] a, input logic [2:0] w);
    exp_arr = 0;
    for (int k = 0; k < int'(w); k++) exp_arr[8*k +: 8] = sh[8'(a + k)];
  endfunction

  function automatic logic [31:0] rep(input logic [7:0] b, input logic [2:0] w);
    rep = 0;
    for (int k = 0; k < int'(w); k++) rep[8*k +: 8] = b;
  endfunction

  function automatic void sh_store(input logic [7:0] a, input logic [31:0] d, input logic [2:0] w);
    for (int k = 0; k < int'(w); k++) sh[8'(a + k)] = d[8*k +: 8];
  endfunction

  function automatic logic [2:0] rw();
    rw = 3'd1 << ($urandom % 3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); bd_we = 1; bd_addr = 8'(i); bd_data = 8'($urandom); sh[i] = bd_data;
    end
    @(negedge clk); bd_we = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    chk("R1 rdata after reset", rdata, 32'h0);
    rd(8'h05, 3'd4, v); chk("R1 array mode after reset", v, exp_arr(8'h05, 3'd4));

    for (int i = 0; i < 40; i++) begin
      logic [7:0] a; logic [2:0] w;
      a = 8'($urandom); w = rw();
      rd(a, w, v); chk("R2 random array read", v, exp_arr(a, w));
    end
    rd(8'hFE, 3'd4, v); chk("R2 wrap read", v, exp_arr(8'hFE, 3'd4));

    wr(8'h00, 32'h70, 3'd1);
    rd(8'h00, 3'd1, v); chk("R1 reset status", v, 32'h80);
    wr(8'h00, 32'hF0, 3'd1);
    rd(8'h11, 3'd2, v); chk("R3 F0 read array", v, exp_arr(8'h11, 3'd2));
    wr(8'h00, 32'h70, 3'd1);
    wr(8'h00, 32'h00, 3'd1);
    rd(8'h21, 3'd1, v); chk("R3 00 read array", v, exp_arr(8'h21, 3'd1));
    wr(8'h00, 32'h90, 3'd1);
    wr(8'h00, 32'hFF, 3'd1);
    rd(8'h31, 3'd4, v); chk("R3 FF read array", v, exp_arr(8'h31, 3'd4));

    for (int i = 0; i < 30; i++) begin
      logic [7:0] a; logic [2:0] w; logic [31:0] d;
      a = 8'($urandom); w = rw(); d = $urandom;
      wr(8'h00, (i % 2) ? 32'h40 : 32'h10, 3'd1);
      wr(a, d, w); sh_store(a, d, w);
      rd(a, 3'd4, v); chk("R4 status after program", v, 32'h80808080);
      wr(8'h00, 32'hFF, 3'd1);
      rd(a, w, v); chk("R4 program readback", v, exp_arr(a, w));
    end

    wr(8'h00, 32'h70, 3'd1);
    rd(8'h00, 3'd1, v); chk("R8 status width 1", v, 32'h80);
    rd(8'h00, 3'd2, v); chk("R8 status width 2", v, 32'h8080);
    rd(8'h00, 3'd4, v); chk("R8 status width 4", v, 32'h80808080);

    ro = 1;
    wr(8'h00, 32'h40, 3'd1);
    wr(8'h10, 32'hA5A5A5A5, 3'd4);
    rd(8'h00, 3'd1, v); chk("R5 read-only program flag", v, 32'h90);
    wr(8'h00, 32'h50, 3'd1);
    wr(8'h80, 32'h20, 3'd1);
    wr(8'h80, 32'hD0, 3'd1);
    rd(8'h00, 3'd1, v); chk("R5 read-only erase flag", v, 32'hA0);
    wr(8'h00, 32'hFF, 3'd1);
    rd(8'h10, 3'd4, v); chk("R5 array kept after ro program", v, exp_arr(8'h10, 3'd4));
    rd(8'h80, 3'd4, v); chk("R5 array kept after ro erase", v, exp_arr(8'h80, 3'd4));
    ro = 0;

    wr(8'h00, 32'h50, 3'd1);
    rd(8'h44, 3'd1, v); chk("R7 clear returns to array", v, exp_arr(8'h44, 3'd1));
    wr(8'h00, 32'h70, 3'd1);
    rd(8'h00, 3'd1, v); chk("R7 status cleared", v, 32'h00);

    wr(8'h47, 32'h20, 3'd1);
    for (int i = 64; i < 128; i++) sh[i] = 8'hFF;
    wr(8'h47, 32'hD0, 3'd1);
    chk("R6 confirm no error", {31'b0, last_err}, 32'h0);
    rd(8'h00, 3'd1, v); chk("R6 status after erase", v, 32'h80);
    wr(8'h00, 32'hFF, 3'd1);
    rd(8'h3E, 3'd4, v); chk("R6 lower block edge", v, exp_arr(8'h3E, 3'd4));
    rd(8'h7E, 3'd4, v); chk("R6 upper block edge", v, exp_arr(8'h7E, 3'd4));
    rd(8'h60, 3'd4, v); chk("R6 block filled", v, 32'hFFFFFFFF);
    wr(8'hC3, 32'h20, 3'd1);
    for (int i = 192; i < 256; i++) sh[i] = 8'hFF;
    wr(8'hC3, 32'h33, 3'd1);
    chk("R6 bad confirm error", {31'b0, last_err}, 32'h1);
    rd(8'hC0, 3'd2, v); chk("R13 array after bad confirm", v, 32'hFFFF);

    wr(8'h00, 32'h90, 3'd1);
    rd(8'h00, 3'd1, v); chk("R9 manufacturer id", v, 32'h89);
    rd(8'h01, 3'd1, v); chk("R9 device id", v, 32'h18);
    rd(8'h02, 3'd1, v); chk("R9 other index", v, 32'h0);
    rd(8'h00, 3'd4, v); chk("R9 id replicated", v, 32'h89898989);

    wr(8'h00, 32'h98, 3'd1);
    rd(8'h10, 3'd1, v); chk("R10 query Q", v, 32'h51);
    rd(8'h11, 3'd1, v); chk("R10 query R", v, 32'h52);
    rd(8'h12, 3'd2, v); chk("R10 query Y", v, 32'h5959);
    rd(8'h27, 3'd1, v); chk("R10 size byte", v, 32'h08);
    rd(8'h2D, 3'd1, v); chk("R10 block count", v, 32'h03);
    rd(8'h40, 3'd1, v); chk("R10 beyond table", v, 32'h00);
    wr(8'h00, 32'h55, 3'd1);
    rd(8'h10, 3'd1, v); chk("R10 stays in query", v, 32'h51);
    wr(8'h00, 32'hFF, 3'd1);
    rd(8'h10, 3'd1, v); chk("R10 exit query", v, exp_arr(8'h10, 3'd1));

    wr(8'h00, 32'h60, 3'd1);
    wr(8'h00, 32'h01, 3'd1);
    rd(8'h00, 3'd1, v); chk("R11 lock complete status", v, 32'h80);
    wr(8'h00, 32'h60, 3'd1);
    wr(8'h00, 32'h77, 3'd1);
    chk("R11 other value no error", {31'b0, last_err}, 32'h0);
    rd(8'h22, 3'd1, v); chk("R11 other value array", v, exp_arr(8'h22, 3'd1));

    wr(8'h00, 32'hE8, 3'd1);
    wr(8'h00, 32'h03, 3'd1);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] d; d = $urandom;
      wr(8'(8'h08 + 4*i), d, 3'd4); sh_store(8'(8'h08 + 4*i), d, 3'd4);
    end
    wr(8'h00, 32'hD0, 3'd1);
    rd(8'h00, 3'd1, v); chk("R12 confirm status mode", v, 32'h80);
    wr(8'h00, 32'hFF, 3'd1);
    for (int i = 0; i < 4; i++) begin
      rd(8'(8'h08 + 4*i), 3'd4, v); chk("R12 buffered word", v, exp_arr(8'(8'h08 + 4*i), 3'd4));
    end
    wr(8'h00, 32'hE8, 3'd1);
    wr(8'h00, 32'h00, 3'd1);
    wr(8'h30, 32'h0000BEEF, 3'd2); sh_store(8'h30, 32'h0000BEEF, 3'd2);
    wr(8'h00, 32'h22, 3'd1);
    rd(8'h30, 3'd2, v); chk("R12 abort keeps data in array mode", v, 32'hBEEF);
    wr(8'h00, 32'hE8, 3'd1);
    wr(8'h00, 32'hFF, 3'd1);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d; d = 8'($urandom);
      wr(8'(8'hA0 + i), {24'h0, d}, 3'd1); sh_store(8'(8'hA0 + i), {24'h0, d}, 3'd1);
    end
    wr(8'hB0, 32'hD0, 3'd1);
    rd(8'hB0, 3'd1, v); chk("R12 capped count confirm", v, 32'h80);
    wr(8'h00, 32'hFF, 3'd1);
    rd(8'hB0, 3'd1, v); chk("R12 no store past window", v, exp_arr(8'hB0, 3'd1));
    rd(8'hAF, 3'd1, v); chk("R12 last window word", v, exp_arr(8'hAF, 3'd1));

    wr(8'h00, 32'h70, 3'd1);
    wr(8'h00, 32'h33, 3'd1);
    chk("R13 unknown opcode error", {31'b0, last_err}, 32'h1);
    rd(8'h05, 3'd4, v); chk("R13 array after error", v, exp_arr(8'h05, 3'd4));
    @(negedge clk);
    chk("R13 error is one pulse", {31'b0, seq_err}, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule